// File: doc/BRIEF.md
# SIMD Floating-Point Predicate Compare Unit

This unit compares two 128-bit vectors of IEEE-754 values lane by lane and returns a lane mask. The compare predicate comes from an 8-bit immediate. The vector holds either four single-precision lanes or two double-precision lanes.

Each lane falls into exactly one of four classes: greater, less, equal or unordered. The predicate immediate is decoded into one outcome bit per class, and the lane result is the outcome bit for the lane's class. Code bits 2:0 pick one of eight base predicates, and bit 3 flips the unordered outcome, which gives sixteen predicates from one small table.

In packed mode every lane is compared. In scalar mode only lane 0 is compared, and the upper lanes of the result are taken from operand A. The result is registered one cycle after the input strobe.

Top module: `fcmp_unit`

## Requirements
- R1: If any of immediate bits 7:5 is set, the immediate is illegal. `illegal_o` is then 1 and the whole of `res_o` is zero in the output cycle.
- R2: Immediate bits 2:0 select the outcome bits (gt,lt,eq,un): 0 eq (0,0,1,0); 1 lt (0,1,0,0); 2 le (0,1,1,0); 3 unordered (0,0,0,1); 4 not-equal (1,1,0,1); 5 not-less (1,0,1,1); 6 not-less-or-equal (1,0,0,1); 7 ordered (1,1,1,0).
- R3: When immediate bit 3 is 1, the unordered outcome bit from R2 is inverted. Code 11 is therefore always false and code 15 is always true.
- R4: Immediate bit 4 (quiet/signaling) has no effect on the result.
- R5: A value is NaN when its exponent field is all ones and its mantissa is nonzero, quiet or signaling alike. A lane with a NaN in either operand is unordered. An infinity is not a NaN.
- R6: Lanes that are not NaN are ordered by sign and magnitude, with infinities included. +0 and -0 compare equal.
- R7: A true lane is all ones and a false lane is all zeros. `dbl_i`=0 gives four 32-bit lanes and `dbl_i`=1 gives two 64-bit lanes, with lane 0 in the least significant bits.
- R8: With `scalar_i`=1, only lane 0 is compared and every other lane of `res_o` equals the same lane of `a_i`.
- R9: `valid_o` rises one cycle after `valid_i`. While `valid_i` is low, `res_o` and `illegal_o` hold their values.
- R10: Under reset, `valid_o`, `illegal_o` and `res_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| valid_i | input | 1 | operands and controls valid |
| a_i | input | 128 | operand A |
| b_i | input | 128 | operand B |
| imm_i | input | 8 | predicate immediate |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision |
| scalar_i | input | 1 | 1 = compare lane 0 only |
| valid_o | output | 1 | result valid |
| res_o | output | 128 | lane mask / passthrough result |
| illegal_o | output | 1 | immediate had bits above 4 set |

## Verification
The hardest case to reach is a packed vector whose lanes fall into different classes under one predicate. In that case a lane-select or lane-width fault shows up as a mask that is wrong in only some lanes. The stimulus table spreads consecutive operand pairs across neighbouring lanes. Each of the sixteen predicates is applied to every rotation of the table, so that every lane position sees every class, including signaling NaNs, infinities and signed zeros. Bit 4 is toggled between table entries.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef enum logic [1:0] {CLS_GT = 2'd0, CLS_LT = 2'd1, CLS_EQ = 2'd2, CLS_UN = 2'd3} cls_e;

  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
    logic un;
  } outc_t;

  function automatic logic pick(outc_t o, cls_e c);
    case (c)
      CLS_GT:  return o.gt;
      CLS_LT:  return o.lt;
      CLS_EQ:  return o.eq;
      default: return o.un;
    endcase
  endfunction
endpackage

// File: rtl/fcmp_pred_dec.sv
module fcmp_pred_dec
  import fcmp_pkg::*;
#(
  parameter int IMM_W  = 8,
  parameter int USED_W = 5
) (
  input  logic [IMM_W-1:0] imm_i,
  output outc_t            outc_o,
  output logic             illegal_o
);
  logic [IMM_W-1:0] hi;
  outc_t base;

  assign hi        = imm_i >> USED_W;
  assign illegal_o = |hi;

  always_comb begin
    case (imm_i[2:0])
      3'd0: base = '{gt: 1'b0, lt: 1'b0, eq: 1'b1, un: 1'b0};
      3'd1: base = '{gt: 1'b0, lt: 1'b1, eq: 1'b0, un: 1'b0};
      3'd2: base = '{gt: 1'b0, lt: 1'b1, eq: 1'b1, un: 1'b0};
      3'd3: base = '{gt: 1'b0, lt: 1'b0, eq: 1'b0, un: 1'b1};
      3'd4: base = '{gt: 1'b1, lt: 1'b1, eq: 1'b0, un: 1'b1};
      3'd5: base = '{gt: 1'b1, lt: 1'b0, eq: 1'b1, un: 1'b1};
      3'd6: base = '{gt: 1'b1, lt: 1'b0, eq: 1'b0, un: 1'b1};
      default: base = '{gt: 1'b1, lt: 1'b1, eq: 1'b1, un: 1'b0};
    endcase
    outc_o    = base;
    // bit 3 flips the unordered outcome; bit 4 (quiet/signal) ignored
    outc_o.un = base.un ^ imm_i[3];
  end
endmodule

// File: rtl/fcmp_lane_cls.sv
module fcmp_lane_cls
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output cls_e         cls_o
);
  logic         sa, sb, nan_a, nan_b, mag_lt;
  logic [W-2:0] mag_a, mag_b;

  assign sa     = a_i[W-1];
  assign sb     = b_i[W-1];
  assign mag_a  = a_i[W-2:0];
  assign mag_b  = b_i[W-2:0];
  assign nan_a  = (&a_i[W-2:MAN_W]) && (|a_i[MAN_W-1:0]);
  assign nan_b  = (&b_i[W-2:MAN_W]) && (|b_i[MAN_W-1:0]);
  assign mag_lt = mag_a < mag_b;

  always_comb begin
    if (nan_a || nan_b)                              cls_o = CLS_UN;
    else if ((mag_a == '0 && mag_b == '0) || a_i == b_i) cls_o = CLS_EQ;
    else if (sa != sb)                               cls_o = sa ? CLS_LT : CLS_GT;
    else if (sa)                                     cls_o = mag_lt ? CLS_GT : CLS_LT;
    else                                             cls_o = mag_lt ? CLS_LT : CLS_GT;
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int IMM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             dbl_i,
  input  logic             scalar_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] res_o,
  output logic             illegal_o
);
  localparam int SP_W = 32;
  localparam int DP_W = 64;
  localparam int SP_N = VEC_W / SP_W;
  localparam int DP_N = VEC_W / DP_W;

  outc_t            outc;
  logic             illegal;
  logic [VEC_W-1:0] sp_vec, dp_vec, res_d;

  fcmp_pred_dec #(.IMM_W(IMM_W), .USED_W(5)) u_dec (
    .imm_i    (imm_i),
    .outc_o   (outc),
    .illegal_o(illegal)
  );

  for (genvar g = 0; g < SP_N; g++) begin : g_sp
    cls_e cls;
    fcmp_lane_cls #(.EXP_W(8), .MAN_W(23)) u_cls (
      .a_i  (a_i[g*SP_W +: SP_W]),
      .b_i  (b_i[g*SP_W +: SP_W]),
      .cls_o(cls)
    );
    if (g == 0) begin : g_l0
      assign sp_vec[g*SP_W +: SP_W] = {SP_W{pick(outc, cls)}};
    end else begin : g_up
      assign sp_vec[g*SP_W +: SP_W] = scalar_i ? a_i[g*SP_W +: SP_W] : {SP_W{pick(outc, cls)}};
    end
  end

  for (genvar g = 0; g < DP_N; g++) begin : g_dp
    cls_e cls;
    fcmp_lane_cls #(.EXP_W(11), .MAN_W(52)) u_cls (
      .a_i  (a_i[g*DP_W +: DP_W]),
      .b_i  (b_i[g*DP_W +: DP_W]),
      .cls_o(cls)
    );
    if (g == 0) begin : g_l0
      assign dp_vec[g*DP_W +: DP_W] = {DP_W{pick(outc, cls)}};
    end else begin : g_up
      assign dp_vec[g*DP_W +: DP_W] = scalar_i ? a_i[g*DP_W +: DP_W] : {DP_W{pick(outc, cls)}};
    end
  end

  assign res_d = illegal ? '0 : (dbl_i ? dp_vec : sp_vec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      res_o     <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o     <= res_d;
        illegal_o <= illegal;
      end
    end
  end
endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [127:0] a_i,
  input logic [7:0]   imm_i,
  input logic         dbl_i,
  input logic         scalar_i,
  input logic         valid_o,
  input logic [127:0] res_o,
  input logic         illegal_o
);
  p_illegal_flag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (imm_i[7:5] != 3'd0) |=> illegal_o && res_o == '0);

  p_legal_flag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (imm_i[7:5] == 3'd0) |=> !illegal_o);

  p_lane_uniform_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !scalar_i && !dbl_i |=>
      ($countones(res_o[31:0]) % 32 == 0) && ($countones(res_o[63:32]) % 32 == 0) &&
      ($countones(res_o[95:64]) % 32 == 0) && ($countones(res_o[127:96]) % 32 == 0));

  p_scalar_sp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && scalar_i && !dbl_i && (imm_i[7:5] == 3'd0) |=> res_o[127:32] == $past(a_i[127:32]));

  p_scalar_dp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && scalar_i && dbl_i && (imm_i[7:5] == 3'd0) |=> res_o[127:64] == $past(a_i[127:64]));

  p_valid_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(res_o) && $stable(illegal_o));
endmodule

bind fcmp_unit fcmp_unit_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .a_i      (a_i),
  .imm_i    (imm_i),
  .dbl_i    (dbl_i),
  .scalar_i (scalar_i),
  .valid_o  (valid_o),
  .res_o    (res_o),
  .illegal_o(illegal_o)
);

// File: tb/fcmp_unit_tb.sv
module fcmp_unit_tb;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] a_i = '0, b_i = '0;
  logic [7:0]   imm_i = '0;
  logic         dbl_i = 1'b0, scalar_i = 1'b0;
  logic         valid_o, illegal_o;
  logic [127:0] res_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  fcmp_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .imm_i(imm_i), .dbl_i(dbl_i), .scalar_i(scalar_i),
    .valid_o(valid_o), .res_o(res_o), .illegal_o(illegal_o)
  );

  // entry: {a32, b32, a64, b64, class}; class 0=gt 1=lt 2=eq 3=unordered
  localparam int N = 12;
  localparam logic [193:0] TBL [N] = '{
    {32'h3f800000, 32'h3f800000, 64'h3ff0000000000000, 64'h3ff0000000000000, 2'd2},
    {32'h00000000, 32'h3f800000, 64'h0000000000000000, 64'h3ff0000000000000, 2'd1},
    {32'h3f800000, 32'h00000000, 64'h3ff0000000000000, 64'h0000000000000000, 2'd0},
    {32'h7fc00000, 32'h00000000, 64'h7ff8000000000000, 64'h0000000000000000, 2'd3},
    {32'h00000000, 32'h7fc00000, 64'h0000000000000000, 64'h7ff8000000000000, 2'd3},
    {32'h7fc00000, 32'h7fc00000, 64'h7ff8000000000000, 64'h7ff8000000000000, 2'd3},
    {32'h00000000, 32'h80000000, 64'h0000000000000000, 64'h8000000000000000, 2'd2},
    {32'hff800000, 32'h7f800000, 64'hfff0000000000000, 64'h7ff0000000000000, 2'd1},
    {32'hbf800000, 32'hc0000000, 64'hbff0000000000000, 64'hc000000000000000, 2'd0},
    {32'h7f800001, 32'h3f800000, 64'h7ff0000000000001, 64'h3ff0000000000000, 2'd3},
    {32'h7f800000, 32'h40400000, 64'h7ff0000000000000, 64'h4008000000000000, 2'd0},
    {32'hc0000000, 32'h3f800000, 64'hc000000000000000, 64'h3ff0000000000000, 2'd1}
  };

  function automatic logic ref_pred(int code, int c);
    logic gt, lt, eq, un;
    gt = (c == 0); lt = (c == 1); eq = (c == 2); un = (c == 3);
    case (code)
      0: return eq;          1: return lt;
      2: return lt | eq;     3: return un;
      4: return !eq;         5: return !lt;
      6: return !(lt | eq);  7: return !un;
      8: return eq | un;     9: return lt | un;
      10: return !gt;        11: return 1'b0;
      12: return gt | lt;    13: return gt | eq;
      14: return gt;         default: return 1'b1;
    endcase
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  task automatic apply(logic [127:0] a, logic [127:0] b, logic [7:0] imm, logic dbl, logic sc);
    @(negedge clk);
    a_i = a; b_i = b; imm_i = imm; dbl_i = dbl; scalar_i = sc; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] a, b, e, held;
    // R10 reset state
    #12;
    chk("R10 reset", {res_o[127:2], valid_o, illegal_o}, '0);
    @(negedge clk); rst_ni = 1'b1;

    // table sweep: R2 R3 R5 R6 R7, bit 4 toggled for R4
    for (int code = 0; code < 16; code++) begin
      for (int en = 0; en < N; en++) begin
        for (int d = 0; d < 2; d++) begin
          a = '0; b = '0; e = '0;
          if (d == 0) begin
            for (int l = 0; l < 4; l++) begin
              a[l*32 +: 32] = TBL[(en+l)%N][193:162];
              b[l*32 +: 32] = TBL[(en+l)%N][161:130];
              e[l*32 +: 32] = {32{ref_pred(code, int'(TBL[(en+l)%N][1:0]))}};
            end
          end else begin
            for (int l = 0; l < 2; l++) begin
              a[l*64 +: 64] = TBL[(en+l)%N][129:66];
              b[l*64 +: 64] = TBL[(en+l)%N][65:2];
              e[l*64 +: 64] = {64{ref_pred(code, int'(TBL[(en+l)%N][1:0]))}};
            end
          end
          apply(a, b, 8'(code | ((en & 1) << 4)), d[0], 1'b0);
          chk($sformatf("%s R4 R5 R6 R7 code=%0d en=%0d dbl=%0d", code < 8 ? "R2" : "R3", code, en, d),
              res_o, e);
        end
      end
    end

    // R9 latency
    apply(TBL[0][193:66], TBL[0][129:2], 8'd0, 1'b0, 1'b0);
    chk("R9 valid_o high", {127'd0, valid_o}, 128'd1);

    // R1 illegal immediates
    apply({4{32'h3f800000}}, {4{32'h3f800000}}, 8'h20, 1'b0, 1'b0);
    chk("R1 res zero 0x20", res_o, '0);
    chk("R1 flag 0x20", {127'd0, illegal_o}, 128'd1);
    apply({4{32'h3f800000}}, {4{32'h3f800000}}, 8'h8f, 1'b1, 1'b0);
    chk("R1 res zero 0x8f", res_o, '0);
    chk("R1 flag 0x8f", {127'd0, illegal_o}, 128'd1);
    apply({4{32'h3f800000}}, {4{32'h3f800000}}, 8'h1f, 1'b0, 1'b0);
    chk("R1 legal 0x1f", {127'd0, illegal_o}, 128'd0);
    chk("R3 true code 15", res_o, {128{1'b1}});

    // R4 bit 4 alone
    apply({4{32'h00000000}}, {4{32'h80000000}}, 8'h10, 1'b0, 1'b0);
    chk("R4 bit4 eq", res_o, {128{1'b1}});

    // R8 scalar single: lane0 0<1 with lt
    apply({32'h11111111, 32'h22222222, 32'h7fc00000, 32'h00000000},
          {32'h00000000, 32'h00000000, 32'h00000000, 32'h3f800000}, 8'd1, 1'b0, 1'b1);
    chk("R8 scalar sp", res_o, {32'h11111111, 32'h22222222, 32'h7fc00000, 32'hffffffff});
    // R8 scalar double: lane0 NaN, ord -> false
    apply({64'hdeadbeefcafef00d, 64'h7ff8000000000000},
          {64'h0, 64'h3ff0000000000000}, 8'd7, 1'b1, 1'b1);
    chk("R8 scalar dp", res_o, {64'hdeadbeefcafef00d, 64'h0});

    // R9 hold while valid low
    held = res_o;
    @(negedge clk);
    a_i = '1; b_i = '0; imm_i = 8'd15; dbl_i = 1'b0; scalar_i = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 hold res", res_o, held);
    chk("R9 valid low", {127'd0, valid_o}, 128'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule